// File: doc/BRIEF.md
# SPI Master Packet Transfer Sequencer

This block is the command and sequencing core of an SPI master. Software writes a command word that holds the start commands, the clock mode, the bit order and the interrupt enables. A transfer moves a programmed number of packets, and every packet carries a programmed number of bytes. The block serialises each byte onto the data line and collects the returned byte. It does this on half-period ticks supplied by a separate SCK timing generator. Transmit bytes come from the head of a show-ahead FIFO, and received bytes are pushed to a receive FIFO.

At the end of a transfer the sequencer either releases chip select and returns to idle, or it holds chip select and parks in a paused state until a resume command starts the next transfer. A finish or pause event can raise a sticky interrupt flag. A status read strobe clears that flag. A soft reset command aborts a transfer at any point.

Top module: `spi_pkt_seq`

## Requirements
- R1: After reset the block is idle: `cs_n_o`=1, `sck_o`=0, `busy_o`=0, `paused_o`=0, both flags and `irq_o` are 0.
- R2: A command write with bit 0 (activate) set, made while idle, starts a transfer. From the next cycle `busy_o`=1 and `cs_n_o`=0.
- R3: A transfer moves exactly (`pkt_len_m1_i`+1)×(`pkt_loop_m1_i`+1) bytes. For each byte, `tx_pop_o` pulses with the byte's final tick and `rx_push_o` pulses one cycle later. `busy_o` stays 1 until the last byte completes.
- R4: With bit 4 (pause enable) set, the transfer ends with `paused_o`=1 and `cs_n_o` held at 0. With bit 4 clear, it ends idle with `cs_n_o`=1.
- R5: A write with bit 1 (resume) made while paused starts a new transfer. An activate written while paused, and a resume written while idle, change nothing.
- R6: Bit 9 (CPOL) sets the level of `sck_o` between bytes, and every tick toggles `sck_o`. A byte takes 2×DATA_W ticks. With bit 8 (CPHA) at 0, `mosi_o` is valid before each leading tick and `miso_i` is sampled on it. With bit 8 at 1, both happen on the trailing tick.
- R7: Bit 12 selects MSB-first transmit order and bit 13 selects MSB-first receive order, independently of each other. When a bit is 0 that direction runs LSB first.
- R8: A finish event sets `fin_flag_o` only if bit 16 was set. A pause event sets `pause_flag_o` only if bit 17 was set. The flags are sticky, `irq_o` is their OR, and `stat_rd_i` clears both.
- R9: A write with bit 2 (soft reset) set returns the block to idle at once and raises `cs_n_o`. It also clears the byte and packet counters. It takes priority over activate and resume in the same word.
- R10: Activate or resume written while a transfer is running is ignored: the transfer continues with its original mode and length.
- R11: `sck_tick_i` has no effect unless a transfer is running: `sck_o` holds and no byte is pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 18 | Command word (bit fields per R2 to R9) |
| pkt_len_m1_i | input | LEN_W | Bytes per packet minus one |
| pkt_loop_m1_i | input | LOOP_W | Packets per transfer minus one |
| stat_rd_i | input | 1 | Status read strobe, clears interrupt flags |
| sck_tick_i | input | 1 | Half-period tick from the SCK timing generator |
| tx_data_i | input | DATA_W | Head of the transmit FIFO |
| tx_pop_o | output | 1 | Consume the transmit FIFO head |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| cs_n_o | output | 1 | Chip select, active low |
| rx_push_o | output | 1 | Received byte valid |
| rx_data_o | output | DATA_W | Received byte |
| busy_o | output | 1 | Transfer running |
| paused_o | output | 1 | Status: stopped in the paused state |
| fin_flag_o | output | 1 | Sticky finish interrupt flag |
| pause_flag_o | output | 1 | Sticky pause interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that `sck_tick_i` is a single-cycle pulse and that the packet length and loop inputs stay fixed while a command is written. The ignore property for busy commands also assumes that no tick arrives in the cycle of that write. The status-clear property relies on no event being able to fire while the block is not running. The stimulus meets these assumptions in three ways. It separates ticks with an idle cycle, and it keeps command writes and status reads away from tick cycles. It also preloads the transmit queue with every byte of a transfer, so the FIFO head is always valid.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int CMD_W      = 18;
   localparam int B_ACT      = 0;
   localparam int B_RESUME   = 1;
   localparam int B_SRST     = 2;
   localparam int B_HOLD_EN  = 4;
   localparam int B_CPHA     = 8;
   localparam int B_CPOL     = 9;
   localparam int B_TX_MSB   = 12;
   localparam int B_RX_MSB   = 13;
   localparam int B_FIN_IE   = 16;
   localparam int B_HOLD_IE  = 17;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_HOLD = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic cpha;
      logic cpol;
      logic tx_msb;
      logic rx_msb;
      logic hold_en;
      logic fin_ie;
      logic hold_ie;
   } xfer_mode_t;

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
   import spi_seq_pkg::*;
#(
   parameter int LEN_W  = 10,
   parameter int LOOP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we_i,
   input  logic [CMD_W-1:0]  cmd_word_i,
   input  logic [LEN_W-1:0]  len_m1_i,
   input  logic [LOOP_W-1:0] loop_m1_i,
   input  logic              byte_done_i,
   output seq_state_e        state_o,
   output xfer_mode_t        mode_o,
   output logic              launch_o,
   output logic              srst_o,
   output logic              fin_evt_o,
   output logic              hold_evt_o
);

   seq_state_e        state_q;
   xfer_mode_t        mode_q;
   logic [LEN_W-1:0]  len_q, bcnt_q;
   logic [LOOP_W-1:0] loop_q, lcnt_q;
   logic              srst, go, last;
   logic              unused_cmd;

   assign unused_cmd = ^{cmd_word_i[15:14], cmd_word_i[11:10], cmd_word_i[7:5], cmd_word_i[3]};

   assign srst = cmd_we_i & cmd_word_i[B_SRST];
   assign go   = cmd_we_i & ~srst &
                 ((cmd_word_i[B_ACT]    & (state_q == SQ_IDLE)) |
                  (cmd_word_i[B_RESUME] & (state_q == SQ_HOLD)));
   assign last = (state_q == SQ_RUN) & byte_done_i &
                 (bcnt_q == len_q) & (lcnt_q == loop_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= '{cpha: 1'b0, cpol: 1'b0, tx_msb: 1'b1, rx_msb: 1'b1,
                      hold_en: 1'b0, fin_ie: 1'b0, hold_ie: 1'b0};
         len_q   <= '0;
         loop_q  <= '0;
         bcnt_q  <= '0;
         lcnt_q  <= '0;
      end else if (srst) begin
         state_q <= SQ_IDLE;
         bcnt_q  <= '0;
         lcnt_q  <= '0;
      end else if (go) begin
         state_q        <= SQ_RUN;
         mode_q.cpha    <= cmd_word_i[B_CPHA];
         mode_q.cpol    <= cmd_word_i[B_CPOL];
         mode_q.tx_msb  <= cmd_word_i[B_TX_MSB];
         mode_q.rx_msb  <= cmd_word_i[B_RX_MSB];
         mode_q.hold_en <= cmd_word_i[B_HOLD_EN];
         mode_q.fin_ie  <= cmd_word_i[B_FIN_IE];
         mode_q.hold_ie <= cmd_word_i[B_HOLD_IE];
         len_q          <= len_m1_i;
         loop_q         <= loop_m1_i;
         bcnt_q         <= '0;
         lcnt_q         <= '0;
      end else if ((state_q == SQ_RUN) && byte_done_i) begin
         if (bcnt_q == len_q) begin
            bcnt_q <= '0;
            if (lcnt_q == loop_q) begin
               lcnt_q  <= '0;
               state_q <= mode_q.hold_en ? SQ_HOLD : SQ_IDLE;
            end else begin
               lcnt_q <= lcnt_q + 1'b1;
            end
         end else begin
            bcnt_q <= bcnt_q + 1'b1;
         end
      end
   end

   assign state_o    = state_q;
   assign mode_o     = mode_q;
   assign launch_o   = go;
   assign srst_o     = srst;
   assign fin_evt_o  = last & ~mode_q.hold_en;
   assign hold_evt_o = last &  mode_q.hold_en;

endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
   parameter  int DATA_W = 8,
   localparam int HW     = $clog2(2 * DATA_W),
   localparam int IW     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              run_i,
   input  logic              tick_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              tx_msb_i,
   input  logic              rx_msb_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              miso_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              done_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_byte_o
);

   localparam logic [HW-1:0] H_LAST = HW'(2 * DATA_W - 1);

   logic [HW-1:0]     h_q, h_m1;
   logic [IW-1:0]     tx_idx, rx_idx;
   logic [DATA_W-1:0] tx_rev, tx_ord, acc_q, acc_nx, acc_rev;
   logic              sample;
   logic              unused_h;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
      assign tx_rev[gi]  = tx_byte_i[DATA_W-1-gi];
      assign acc_rev[gi] = acc_nx[DATA_W-1-gi];
   end

   assign h_m1     = h_q - 1'b1;
   assign unused_h = h_m1[0];
   assign rx_idx   = h_q[HW-1:1];
   assign tx_idx   = cpha_i ? ((h_q == '0) ? '0 : h_m1[HW-1:1]) : h_q[HW-1:1];
   assign tx_ord   = tx_msb_i ? tx_rev : tx_byte_i;
   assign mosi_o   = tx_ord[tx_idx];
   assign sck_o    = cpol_i ^ h_q[0];
   assign sample   = run_i & tick_i & ~clr_i & (h_q[0] == cpha_i);
   assign done_o   = run_i & tick_i & ~clr_i & (h_q == H_LAST);

   always_comb begin
      acc_nx = acc_q;
      if (sample) acc_nx[rx_idx] = miso_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q        <= '0;
         acc_q      <= '0;
         rx_valid_o <= 1'b0;
         rx_byte_o  <= '0;
      end else begin
         rx_valid_o <= done_o;
         acc_q      <= acc_nx;
         if (clr_i)
            h_q <= '0;
         else if (run_i && tick_i)
            h_q <= h_q + 1'b1;
         if (done_o)
            rx_byte_o <= rx_msb_i ? acc_rev : acc_nx;
      end
   end

endmodule

// File: rtl/spi_seq_flags.sv
module spi_seq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic fin_evt_i,
   input  logic hold_evt_i,
   input  logic fin_ie_i,
   input  logic hold_ie_i,
   input  logic rd_clr_i,
   output logic fin_flag_o,
   output logic hold_flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fin_flag_o  <= 1'b0;
         hold_flag_o <= 1'b0;
      end else begin
         if (fin_evt_i && fin_ie_i)
            fin_flag_o <= 1'b1;
         else if (rd_clr_i)
            fin_flag_o <= 1'b0;
         if (hold_evt_i && hold_ie_i)
            hold_flag_o <= 1'b1;
         else if (rd_clr_i)
            hold_flag_o <= 1'b0;
      end
   end

endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
   import spi_seq_pkg::*;
#(
   parameter  int DATA_W        = 8,
   parameter  int MAX_PKT_BYTES = 1024,
   parameter  int MAX_LOOPS     = 256,
   localparam int LEN_W         = $clog2(MAX_PKT_BYTES),
   localparam int LOOP_W        = $clog2(MAX_LOOPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we_i,
   input  logic [CMD_W-1:0]  cmd_word_i,
   input  logic [LEN_W-1:0]  pkt_len_m1_i,
   input  logic [LOOP_W-1:0] pkt_loop_m1_i,
   input  logic              stat_rd_i,
   input  logic              sck_tick_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_pop_o,
   input  logic              miso_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              cs_n_o,
   output logic              rx_push_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              busy_o,
   output logic              paused_o,
   output logic              fin_flag_o,
   output logic              pause_flag_o,
   output logic              irq_o
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 2");
   end
   if (MAX_PKT_BYTES < 2 || (MAX_PKT_BYTES & (MAX_PKT_BYTES - 1)) != 0) begin : g_bad_pkt
      $error("MAX_PKT_BYTES must be a power of two of at least 2");
   end
   if (MAX_LOOPS < 2 || (MAX_LOOPS & (MAX_LOOPS - 1)) != 0) begin : g_bad_loops
      $error("MAX_LOOPS must be a power of two of at least 2");
   end

   seq_state_e state;
   xfer_mode_t mode;
   logic       launch, srst, byte_done, fin_evt, hold_evt, run;

   assign run = (state == SQ_RUN);

   spi_seq_ctrl #(.LEN_W(LEN_W), .LOOP_W(LOOP_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we_i    (cmd_we_i),
      .cmd_word_i  (cmd_word_i),
      .len_m1_i    (pkt_len_m1_i),
      .loop_m1_i   (pkt_loop_m1_i),
      .byte_done_i (byte_done),
      .state_o     (state),
      .mode_o      (mode),
      .launch_o    (launch),
      .srst_o      (srst),
      .fin_evt_o   (fin_evt),
      .hold_evt_o  (hold_evt)
   );

   spi_byte_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (srst | launch),
      .run_i      (run),
      .tick_i     (sck_tick_i),
      .cpol_i     (mode.cpol),
      .cpha_i     (mode.cpha),
      .tx_msb_i   (mode.tx_msb),
      .rx_msb_i   (mode.rx_msb),
      .tx_byte_i  (tx_data_i),
      .miso_i     (miso_i),
      .sck_o      (sck_o),
      .mosi_o     (mosi_o),
      .done_o     (byte_done),
      .rx_valid_o (rx_push_o),
      .rx_byte_o  (rx_data_o)
   );

   spi_seq_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .fin_evt_i   (fin_evt),
      .hold_evt_i  (hold_evt),
      .fin_ie_i    (mode.fin_ie),
      .hold_ie_i   (mode.hold_ie),
      .rd_clr_i    (stat_rd_i),
      .fin_flag_o  (fin_flag_o),
      .hold_flag_o (pause_flag_o)
   );

   assign tx_pop_o = byte_done;
   assign busy_o   = run;
   assign paused_o = (state == SQ_HOLD);
   assign cs_n_o   = (state == SQ_IDLE);
   assign irq_o    = fin_flag_o | pause_flag_o;

endmodule

// File: rtl/spi_pkt_seq_chk.sv
module spi_pkt_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_we_i,
   input logic [17:0] cmd_word_i,
   input logic        stat_rd_i,
   input logic        sck_tick_i,
   input logic        tx_pop_o,
   input logic        rx_push_o,
   input logic        sck_o,
   input logic        cs_n_o,
   input logic        busy_o,
   input logic        paused_o,
   input logic        irq_o
);

   // R3: every consumed transmit byte yields a received byte next cycle
   p_push_follows_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop_o |=> rx_push_o);

   // R4: chip select stays active while paused
   p_hold_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      paused_o |-> !cs_n_o);

   // R4: the paused state is entered only from a running transfer
   p_pause_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused_o) |-> $past(busy_o));

   // R8: a status read outside a transfer leaves no interrupt pending
   p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !busy_o) |=> !irq_o);

   // R9: soft reset idles the block and releases chip select
   p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we_i && cmd_word_i[2]) |=> (!busy_o && cs_n_o));

   // R10: commands written during a transfer do not stop it
   p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && cmd_we_i && !cmd_word_i[2] && !sck_tick_i) |=> busy_o);

   // R11: the serial clock holds when nothing runs and no command arrives
   p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !cmd_we_i) |=> $stable(sck_o));

endmodule

bind spi_pkt_seq spi_pkt_seq_chk u_chk (.*);

// File: tb/sim_spi_pkt_seq.sv
module sim_spi_pkt_seq;

   localparam int DW = 8;
   localparam int LW = 10;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [17:0]   cmd_word = '0;
   logic [LW-1:0] len_m1 = '0;
   logic [PW-1:0] loop_m1 = '0;
   logic          stat_rd = 1'b0;
   logic          sck_tick = 1'b0;
   logic          miso = 1'b0;
   logic [DW-1:0] tx_head = '0;
   logic          tx_pop, sck, mosi, cs_n, rx_push, busy, paused, fin_flag, pause_flag, irq;
   logic [DW-1:0] rx_data;

   logic [7:0] tx_q[$];
   logic [7:0] exp_q[$];
   int checks = 0;
   int fails  = 0;
   int pushes = 0;

   always #4 clk = ~clk;

   spi_pkt_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we), .cmd_word_i(cmd_word),
      .pkt_len_m1_i(len_m1), .pkt_loop_m1_i(loop_m1), .stat_rd_i(stat_rd),
      .sck_tick_i(sck_tick), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
      .miso_i(miso), .sck_o(sck), .mosi_o(mosi), .cs_n_o(cs_n),
      .rx_push_o(rx_push), .rx_data_o(rx_data), .busy_o(busy), .paused_o(paused),
      .fin_flag_o(fin_flag), .pause_flag_o(pause_flag), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: compare each received byte against the scoreboard
   always @(negedge clk) begin
      if (rst_n && rx_push) begin
         pushes++;
         if (exp_q.size() == 0) begin
            checks++;
            fails++;
            $display("FAIL R11 unexpected rx byte: actual %0d expected none", rx_data);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rx_data === e, "R7", "rx byte", int'(rx_data), int'(e));
         end
      end
   end

   function automatic logic [17:0] mk(bit act, bit res, bit srst, bit pen, bit cpha, bit cpol,
                                      bit txm, bit rxm, bit fie, bit pie);
      logic [17:0] w;
      w = '0;
      w[0] = act; w[1] = res; w[2] = srst; w[4] = pen;
      w[8] = cpha; w[9] = cpol; w[12] = txm; w[13] = rxm;
      w[16] = fie; w[17] = pie;
      return w;
   endfunction

   task automatic wr(input logic [17:0] w);
      cmd_we = 1'b1;
      cmd_word = w;
      @(negedge clk);
      cmd_we = 1'b0;
      cmd_word = '0;
   endtask

   task automatic rd_status();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic head_refresh();
      tx_head = (tx_q.size() != 0) ? tx_q[0] : '0;
   endtask

   // driver: shift one byte (nt ticks), checking mosi and sck, queueing the expected rx byte
   task automatic shift_byte(input logic [7:0] txb, input logic [7:0] mb, input logic [17:0] w, input int nt);
      bit cpha, cpol, txm, rxm;
      cpha = w[8]; cpol = w[9]; txm = w[12]; rxm = w[13];
      if (nt == 16) exp_q.push_back(mb);
      for (int t = 0; t < nt; t++) begin
         if (t == 0) chk(sck === cpol, "R6", "sck idle level", int'(sck), int'(cpol));
         if ((t % 2) == int'(cpha)) begin
            int j;
            bit eb;
            j = t / 2;
            eb = txm ? txb[7-j] : txb[j];
            chk(mosi === eb, "R7", "mosi bit", int'(mosi), int'(eb));
            miso = rxm ? mb[7-j] : mb[j];
         end
         sck_tick = 1'b1;
         if (t == 15) begin
            #1;
            chk(tx_pop === 1'b1, "R3", "tx_pop on final tick", int'(tx_pop), 1);
         end
         @(negedge clk);
         sck_tick = 1'b0;
         if (t == 15) begin
            void'(tx_q.pop_front());
            head_refresh();
         end
         if (t == 0) chk(sck === ~cpol, "R6", "sck after leading tick", int'(sck), int'(~cpol));
         @(negedge clk);
      end
   endtask

   task automatic run_xfer(input logic [17:0] w, input string sreq, input int lm, input int pm,
                           input int seed, input bit poke, input bit hold);
      int total, p0;
      len_m1 = LW'(lm);
      loop_m1 = PW'(pm);
      total = (lm + 1) * (pm + 1);
      tx_q.delete();
      for (int b = 0; b < total; b++) tx_q.push_back(8'(b * 37 + seed));
      head_refresh();
      p0 = pushes;
      wr(w);
      chk(busy === 1'b1, sreq, "busy after start", int'(busy), 1);
      chk(cs_n === 1'b0, sreq, "cs_n after start", int'(cs_n), 0);
      for (int b = 0; b < total; b++) begin
         if (b == total - 1)
            chk(busy === 1'b1, "R3", "busy before last byte", int'(busy), 1);
         if (poke && b == 1) begin
            wr(w ^ 18'h00203);
            chk(busy === 1'b1, "R10", "busy after command mid-transfer", int'(busy), 1);
         end
         shift_byte(8'(b * 37 + seed), ~8'(b * 11 + seed), w, 16);
      end
      chk(pushes - p0 == total, "R3", "bytes received", pushes - p0, total);
      chk(busy === 1'b0, "R3", "busy after last byte", int'(busy), 0);
      chk(paused === hold, "R4", "paused at end", int'(paused), int'(hold));
      chk(cs_n === !hold, "R4", "cs_n at end", int'(cs_n), int'(!hold));
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [17:0] w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(cs_n === 1'b1, "R1", "cs_n", int'(cs_n), 1);
      chk(sck === 1'b0, "R1", "sck", int'(sck), 0);
      chk(busy === 1'b0, "R1", "busy", int'(busy), 0);
      chk(paused === 1'b0, "R1", "paused", int'(paused), 0);
      chk(irq === 1'b0 && fin_flag === 1'b0 && pause_flag === 1'b0, "R1", "irq", int'(irq), 0);

      // R11 ticks while idle do nothing
      for (int k = 0; k < 4; k++) begin
         sck_tick = 1'b1; @(negedge clk); sck_tick = 1'b0; @(negedge clk);
      end
      chk(sck === 1'b0, "R11", "sck after idle ticks", int'(sck), 0);
      chk(pushes == 0, "R11", "pushes after idle ticks", pushes, 0);

      // R5 resume while idle is ignored
      wr(mk(0,1,0,0,0,0,1,1,0,0));
      chk(busy === 1'b0, "R5", "busy after idle resume", int'(busy), 0);

      // R2 R3 R8 mode 0, MSB both, 3 bytes x 2 packets, finish interrupt
      w = mk(1,0,0,0,0,0,1,1,1,0);
      run_xfer(w, "R2", 2, 1, 5, 0, 0);
      chk(fin_flag === 1'b1, "R8", "finish flag", int'(fin_flag), 1);
      chk(irq === 1'b1, "R8", "irq after finish", int'(irq), 1);
      rd_status();
      chk(irq === 1'b0 && fin_flag === 1'b0, "R8", "irq after status read", int'(irq), 0);

      // R6 R7 R10 mode 3, TX MSB / RX LSB, poke mid-transfer, no interrupt enable
      w = mk(1,0,0,0,1,1,1,0,0,0);
      run_xfer(w, "R2", 0, 2, 90, 1, 0);
      chk(irq === 1'b0 && fin_flag === 1'b0, "R8", "no flag without enable", int'(irq), 0);

      // R4 mode 2, TX LSB / RX MSB, pause enable with pause interrupt
      w = mk(1,0,0,1,0,1,0,1,0,1);
      run_xfer(w, "R2", 1, 0, 17, 0, 1);
      chk(pause_flag === 1'b1, "R8", "pause flag", int'(pause_flag), 1);
      wr(mk(1,0,0,0,0,0,1,1,0,0));
      chk(busy === 1'b0 && paused === 1'b1, "R5", "activate while paused ignored", int'(busy), 0);
      rd_status();
      chk(pause_flag === 1'b0, "R8", "pause flag after read", int'(pause_flag), 0);

      // R5 resume: mode 1, LSB both, 4 bytes, then idle
      w = mk(0,1,0,0,1,0,0,0,0,0);
      run_xfer(w, "R5", 3, 0, 200, 0, 0);

      // R9 soft reset mid-byte
      len_m1 = LW'(3);
      loop_m1 = '0;
      tx_q.delete();
      for (int b = 0; b < 4; b++) tx_q.push_back(8'(b + 60));
      head_refresh();
      w = mk(1,0,0,0,0,1,1,1,0,0);
      wr(w);
      shift_byte(8'(60), 8'hC3, w, 16);
      shift_byte(8'(61), 8'h00, w, 5);
      wr(mk(0,0,1,0,0,0,1,1,0,0));
      chk(busy === 1'b0, "R9", "busy after soft reset", int'(busy), 0);
      chk(cs_n === 1'b1, "R9", "cs_n after soft reset", int'(cs_n), 1);
      chk(sck === 1'b1, "R9", "sck back to idle level", int'(sck), 1);
      // counters cleared: a one-byte transfer ends after exactly one byte
      run_xfer(mk(1,0,0,0,0,0,1,1,0,0), "R9", 0, 0, 33, 0, 0);
      // soft reset wins over activate in the same word
      wr(mk(1,0,1,0,0,0,1,1,0,0));
      chk(busy === 1'b0, "R9", "soft reset priority", int'(busy), 0);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule